// File: doc/BRIEF.md
# Event-to-Priority Interrupt Crossbar

This block steers system events onto the CPU's maskable priority interrupt inputs. There are 128 event lines and twelve outputs. Each output has its own 8-bit select field that names one event line, and the output then copies that line. Output index 0 feeds CPU priority 4 and output index 11 feeds priority 15. Event numbers 0 to 3 are the outputs of the four event combiners. Event numbers 4 to 127 are individual system events. The crossbar treats all of them the same way.

The select fields are packed four to a 32-bit word, so three words hold all twelve. Software reaches them through a small register port with byte write strobes. A single field can therefore be changed without a read-modify-write, and the three neighbouring fields in the same word stay as they were. Each output is a flop. It samples its selected event on every clock edge. A new selection shows at the output on the edge after the edge that stored it.

Top module: `prio_event_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, select field n takes the value n+4 (output 0 selects event 4, output 11 selects event 15). At the same edge every `cpu_irq` bit and `reg_rdata` go to zero.
- R2: On every rising edge with reset released, `cpu_irq[n]` takes the value that `evt_in[s]` had just before that edge, where s is the value held in field n and s is below 128.
- R3: Field n sits in select word n/4, in bits [(n mod 4)*8+7 : (n mod 4)*8]. Select word k sits at byte address 0x104 + 4k, for k = 0, 1, 2.
- R4: A write sets the bytes whose `reg_wstrb` bit is 1 in the addressed word. Every byte whose strobe bit is 0 keeps its value.
- R5: While a field holds a value of 128 or more, its `cpu_irq` bit is 0 at every edge, whatever the event inputs do.
- R6: A write takes effect on the edge that stores it. On the next edge the affected output samples the newly selected event.
- R7: A read request at an edge places the addressed word in `reg_rdata` at that edge. At any edge without a read request, `reg_rdata` becomes zero. A read in the same cycle as a write returns the value from before the write.
- R8: Only the three word-aligned addresses 0x104, 0x108 and 0x10C hit. These addresses return zero on a read and ignore writes:
  - the unused word at 0x100;
  - every other address;
  - any address whose two low bits are not zero.
- R9: Event numbers 0 to 3 (the combiner outputs) can be selected and routed exactly like any other event number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | 128 | Event lines, index = event number |
| reg_wr_en | input | 1 | Register write request |
| reg_rd_en | input | 1 | Register read request |
| reg_addr | input | 12 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_wstrb | input | 4 | Byte write strobes; bit b enables bits [8b+7:8b] |
| reg_rdata | output | 32 | Read data, registered |
| cpu_irq | output | 12 | Routed outputs; bit n feeds CPU priority n+4 |

## Verification
The assertions take for granted that `evt_in` and the register port are steady across each rising edge and hold known values once reset is released. They also assume reset is applied for at least one edge before any register traffic. The bench drives every input at the falling edge and keeps reset low for several cycles at the start. It then mixes directed patterns with random ones. The random patterns include writes with partial strobes and accesses to addresses that miss, such as misaligned, below, above and the unused word. All of this stays inside those assumptions.

// File: rtl/prio_route_pkg.sv
// Package: shared widths, the select-field type, and the reset default rule.
// Assumes the register word width is a whole multiple of the field width.
package prio_route_pkg;

    localparam int WORD_W          = 32;
    localparam int SEL_W           = 8;
    localparam int FIELDS_PER_WORD = WORD_W / SEL_W;
    localparam int STRB_W          = WORD_W / 8;

    typedef logic [SEL_W-1:0] sel_t;

    // Value that field idx takes at reset: output idx selects event idx+first_src.
    function automatic sel_t reset_sel(input int idx, input int first_src);
        return sel_t'(idx + first_src);
    endfunction

endpackage

// File: rtl/route_sel_regs.sv
// Module: select-field register file.
// Holds one byte-wide select field per output, four fields packed per word.
// Writes are byte-strobed. Reads are registered and return zero when the
// request misses or when no read is requested.
// Assumes that bus inputs are steady across each rising clock edge.
module route_sel_regs
    import prio_route_pkg::*;
#(
    parameter int NUM_OUTS  = 12,
    parameter int ADDR_W    = 12,
    parameter int BASE_ADDR = 'h104,
    parameter int FIRST_SRC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    output sel_t              sel_o [NUM_OUTS],
    output logic [WORD_W-1:0] rdata
);

    localparam int NUM_WORDS = (NUM_OUTS + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;
    localparam int WA_W      = ADDR_W - 2;
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam logic [WA_W-1:0] BASE_WORD = WA_W'(BASE_ADDR / 4);
    localparam logic [WA_W-1:0] WORDS_V   = WA_W'(NUM_WORDS);

    logic [WA_W-1:0]   word_addr;
    logic [WA_W-1:0]   word_off;
    logic [WIDX_W-1:0] widx;
    logic              hit;
    logic [WORD_W-1:0] rd_word;
    sel_t              sel_q [NUM_OUTS];

    // Address decode: an aligned word inside the select block.
    always_comb begin
        word_addr = addr[ADDR_W-1:2];
        word_off  = word_addr - BASE_WORD;
        hit       = (addr[1:0] == 2'b00) && (word_addr >= BASE_WORD) && (word_off < WORDS_V);
        widx      = word_off[WIDX_W-1:0];
    end

    for (genvar n = 0; n < NUM_OUTS; n++) begin : g_field
        localparam int W = n / FIELDS_PER_WORD;
        localparam int B = n % FIELDS_PER_WORD;
        logic wr_field;

        assign wr_field = wr_en && hit && (widx == WIDX_W'(W)) && wstrb[B];

        // Field storage: reset default, else take the strobed byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[n] <= reset_sel(n, FIRST_SRC);
            else if (wr_field)
                sel_q[n] <= wdata[B*SEL_W +: SEL_W];
        end

        assign sel_o[n] = sel_q[n];

        // R1: reset loads the default selection
        assert_reset_default_R1: assert property (@(posedge clk)
            !rst_n |=> sel_q[n] == reset_sel(n, FIRST_SRC));

        // R4: a strobed byte of the addressed word lands in its field
        assert_strobe_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && hit && widx == WIDX_W'(W) && wstrb[B])
            |=> sel_q[n] == $past(wdata[B*SEL_W +: SEL_W]));

        // R4/R8: without a strobed hit on this byte the field keeps its value
        assert_keep_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && hit && widx == WIDX_W'(W) && wstrb[B]) |=> $stable(sel_q[n]));
    end

    // Read word assembly from the fields of the addressed word.
    always_comb begin
        rd_word = '0;
        for (int n = 0; n < NUM_OUTS; n++) begin
            if (widx == WIDX_W'(n / FIELDS_PER_WORD))
                rd_word[(n % FIELDS_PER_WORD)*SEL_W +: SEL_W] = sel_q[n];
        end
    end

    // Registered read data: the word on a hit, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en && hit)
            rdata <= rd_word;
        else
            rdata <= '0;
    end

    // R8: a read that misses returns zero
    assert_miss_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> rdata == '0);

    // R7: no read request gives zero read data
    assert_idle_rdata_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0);

endmodule

// File: rtl/route_lane.sv
// Module: one routed output.
// Samples the event named by its select field into a flop on every edge.
// A select value at or above NUM_EVENTS drives the output low.
// Assumes NUM_EVENTS is a power of two that fits in the select field.
module route_lane
    import prio_route_pkg::*;
#(
    parameter int NUM_EVENTS = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] evt_in,
    input  sel_t                  sel_i,
    output logic                  irq_o
);

    localparam int IDX_W = $clog2(NUM_EVENTS);
    localparam logic [SEL_W:0] LIMIT = (SEL_W+1)'(NUM_EVENTS);

    logic             in_range;
    logic [IDX_W-1:0] idx;

    // Range check and event index taken from the select field.
    always_comb begin
        in_range = {1'b0, sel_i} < LIMIT;
        idx      = sel_i[IDX_W-1:0];
    end

    // Output flop: the selected event, or low when the select is out of range.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= in_range ? evt_in[idx] : 1'b0;
    end

    // R2: output follows the event chosen one edge earlier
    assert_follow_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, sel_i} < LIMIT) |=> irq_o == $past(evt_in[sel_i[IDX_W-1:0]]));

    // R5: an out-of-range select holds the output low
    assert_out_of_range_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, sel_i} >= LIMIT) |=> !irq_o);

endmodule

// File: rtl/prio_event_router.sv
// Module: top of the event-to-priority crossbar.
// Ties the select register file to one routing lane per CPU priority input.
// Output index 0 feeds the lowest routed priority.
// Assumes synchronous inputs and reset held for at least one edge.
module prio_event_router
    import prio_route_pkg::*;
#(
    parameter int NUM_EVENTS = 128,
    parameter int NUM_OUTS   = 12,
    parameter int ADDR_W     = 12,
    parameter int BASE_ADDR  = 'h104,
    parameter int FIRST_SRC  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] evt_in,
    input  logic                  reg_wr_en,
    input  logic                  reg_rd_en,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    input  logic [3:0]            reg_wstrb,
    output logic [31:0]           reg_rdata,
    output logic [NUM_OUTS-1:0]   cpu_irq
);

    sel_t sel_w [NUM_OUTS];

    route_sel_regs #(
        .NUM_OUTS (NUM_OUTS),
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR),
        .FIRST_SRC(FIRST_SRC)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(reg_wr_en),
        .rd_en(reg_rd_en),
        .addr (reg_addr),
        .wdata(reg_wdata),
        .wstrb(reg_wstrb),
        .sel_o(sel_w),
        .rdata(reg_rdata)
    );

    for (genvar n = 0; n < NUM_OUTS; n++) begin : g_lane
        route_lane #(
            .NUM_EVENTS(NUM_EVENTS)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_in(evt_in),
            .sel_i (sel_w[n]),
            .irq_o (cpu_irq[n])
        );
    end

    // R1: outputs are low on the edge after reset
    assert_outputs_low_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (cpu_irq == '0) && (reg_rdata == '0));

endmodule

// File: tb/tb_prio_event_router.sv
`timescale 1ns/1ps
module tb_prio_event_router;

    localparam int NEV  = 128;
    localparam int NOUT = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NEV-1:0] evt_in = '0;
    logic           reg_wr_en = 1'b0;
    logic           reg_rd_en = 1'b0;
    logic [11:0]    reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [3:0]     reg_wstrb = '0;
    logic [31:0]    reg_rdata;
    logic [NOUT-1:0] cpu_irq;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    // Reference state
    int          ref_sel [NOUT];
    logic [NOUT-1:0] exp_irq = '0;
    logic [31:0] exp_rd = '0;
    bit          model_valid = 0;

    always #2 clk = ~clk;

    prio_event_router dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wstrb(reg_wstrb),
        .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
    );

    // R3/R8: word index for a byte address, -1 when it misses
    function automatic int word_of(input int a);
        if ((a % 4) != 0) return -1;
        if (a == 'h104) return 0;
        if (a == 'h108) return 1;
        if (a == 'h10C) return 2;
        return -1;
    endfunction

    // Behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NOUT; n++) ref_sel[n] = n + 4;   // R1
            exp_irq = '0;
            exp_rd = '0;
            model_valid = 1;
        end else begin
            int w;
            for (int n = 0; n < NOUT; n++)                        // R2, R5
                exp_irq[n] = (ref_sel[n] < NEV) ? evt_in[ref_sel[n]] : 1'b0;
            w = word_of(int'(reg_addr));
            exp_rd = '0;                                          // R7: old value on read
            if (reg_rd_en && w >= 0)
                for (int b = 0; b < 4; b++) exp_rd[b*8 +: 8] = 8'(ref_sel[w*4+b]);
            if (reg_wr_en && w >= 0)                              // R4, R6
                for (int b = 0; b < 4; b++)
                    if (reg_wstrb[b]) ref_sel[w*4+b] = int'(reg_wdata[b*8 +: 8]);
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (model_valid) begin
            checks++;
            if (cpu_irq !== exp_irq) begin
                fails++;
                $display("FAIL %s cpu_irq actual=%03h expected=%03h at %0t", cur_req, cpu_irq, exp_irq, $time);
            end
            checks++;
            if (reg_rdata !== exp_rd) begin
                fails++;
                $display("FAIL %s reg_rdata actual=%08h expected=%08h at %0t", cur_req, reg_rdata, exp_rd, $time);
            end
        end
    end

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            reg_wr_en = 0; reg_rd_en = 0;
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        reg_wr_en = 1; reg_rd_en = 0; reg_addr = 12'(a); reg_wdata = d; reg_wstrb = s;
    endtask

    task automatic bus_read(input int a);
        @(negedge clk);
        reg_wr_en = 0; reg_rd_en = 1; reg_addr = 12'(a);
    endtask

    task automatic rand_events(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            reg_wr_en = 0; reg_rd_en = 0;
            evt_in = {$urandom, $urandom, $urandom, $urandom};
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        evt_in = '1;
        idle(4);
        @(negedge clk); rst_n = 1;
        bus_read('h104); bus_read('h108); bus_read('h10C);
        idle(2);

        // R2: default routing under random events
        cur_req = "R2";
        rand_events(40);

        // R9: combiner sources 0..3 routed
        cur_req = "R9";
        bus_write('h104, 32'h03020100, 4'hF);
        rand_events(30);

        // R6: rewrite while events toggle; per-cycle model fixes the timing
        cur_req = "R6";
        for (int i = 0; i < 8; i++) begin
            bus_write('h108, {$urandom} & 32'h7F7F7F7F, 4'hF);
            evt_in = {$urandom, $urandom, $urandom, $urandom};
        end
        rand_events(5);

        // R4: partial strobes keep the other bytes
        cur_req = "R4";
        bus_write('h108, 32'h11223344, 4'b0100);
        bus_write('h10C, 32'h55667788, 4'b1001);
        bus_read('h108); bus_read('h10C);
        rand_events(10);

        // R5: out-of-range selects drive low
        cur_req = "R5";
        bus_write('h10C, {8'd255, 8'd128, 8'd127, 8'd200}, 4'hF);
        @(negedge clk); reg_wr_en = 0; evt_in = '1;
        idle(5);
        rand_events(10);

        // R3: walk each field, light only its chosen event
        cur_req = "R3";
        for (int n = 0; n < NOUT; n++) begin
            int s;
            s = (n * 11 + 17) % NEV;
            bus_write('h104 + (n / 4) * 4, 32'(s) << ((n % 4) * 8), 4'(1 << (n % 4)));
            @(negedge clk); reg_wr_en = 0; evt_in = '0; evt_in[s] = 1'b1;
            idle(2);
        end

        // R8: misses, the unused word and misaligned addresses
        cur_req = "R8";
        bus_write('h100, 32'hFFFFFFFF, 4'hF);
        bus_write('h110, 32'hFFFFFFFF, 4'hF);
        bus_write('h105, 32'hFFFFFFFF, 4'hF);
        bus_write('h004, 32'hFFFFFFFF, 4'hF);
        bus_read('h100); bus_read('h110); bus_read('h000); bus_read('h106);
        bus_read('h104); bus_read('h108); bus_read('h10C);
        idle(2);

        // R7: read with a write in the same cycle, then idle zeroes
        cur_req = "R7";
        @(negedge clk);
        reg_wr_en = 1; reg_rd_en = 1; reg_addr = 12'h108; reg_wdata = 32'h0A0B0C0D; reg_wstrb = 4'hF;
        bus_read('h108);
        idle(3);

        // R2: random mixed traffic
        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            int pick;
            @(negedge clk);
            pick = int'($urandom % 8);
            reg_wr_en = ($urandom % 3) == 0;
            reg_rd_en = ($urandom % 2) == 0;
            reg_addr  = (pick < 6) ? 12'('h104 + (pick % 3) * 4) : 12'($urandom % 'h120);
            reg_wdata = $urandom;
            reg_wstrb = 4'($urandom);
            evt_in = {$urandom, $urandom, $urandom, $urandom};
        end
        idle(3);
        finish_run();
    end

    // Watchdog
    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule